// File: doc/BRIEF.md
# FIFO Flag Offset Loader

This block keeps the two programmable flag thresholds of a deep FIFO, one for the almost-empty side and one for the almost-full side. Each threshold is 16 bits and lives in two byte registers. Four control pins are decoded into one of several actions: a load-select level, plus active-low write, read and serial enables. Those actions either touch the threshold registers or become plain write and read strobes for the FIFO memory. Both thresholds are presented continuously on wide outputs for the flag comparators.

Programming has two forms, and the form is fixed while master reset is held. In parallel form, each write-clock edge stores one byte from the 9-bit data bus, and a byte pointer selects the register. In serial form, each write-clock edge shifts one bit into a 32-bit chain that covers both thresholds. Readback is always parallel, on the read clock, through a separate byte pointer. The level of the load-select pin during master reset picks which set of default thresholds is loaded.

All pins are plain level controls. No data path in this block carries a handshake. Every action is decided only by the pin levels seen at the relevant clock edge, so there is no back-pressure.

Top module: `fifo_offset_loader`

## Requirements
- R1: With `load_sel`=1: `wr_n`=0 raises `mem_wr`; `wr_n`=1 with `rd_n`=0 raises `mem_rd`; `wr_n`=1 with `rd_n`=1 raises neither. `ser_n` has no effect in any of these cases. With `load_sel`=0, both strobes stay low.
- R2: Master reset (`mrst`=1, synchronous to each clock) with `load_sel`=0 loads both thresholds to 127. Each low byte becomes 7Fh and each high byte becomes 00h.
- R3: Master reset with `load_sel`=1 loads both thresholds to 1023. Each low byte becomes FFh and each high byte becomes 03h.
- R4: In parallel form, a write-clock edge with `load_sel`=0, `wr_n`=0, `rd_n`=1, `ser_n`=1 stores `din[7:0]`. Successive writes go to the empty low byte, then the empty high byte, then the full low byte, then the full high byte. The fifth write wraps back to the empty low byte, and master reset returns the pointer to the empty low byte.
- R5: A read-clock edge with `load_sel`=0, `wr_n`=1, `rd_n`=0, `ser_n`=1 puts the next byte on `dout[7:0]` at that edge, using the same four-register order with wrap. `dout[8]` is 0. `dout` holds its value between reads and is 0 after reset.
- R6: In serial form, a write-clock edge with `load_sel`=0, `wr_n`=1, `rd_n`=1, `ser_n`=0 shifts `ser_din` in. After 32 shifts, the first bit sits in empty-threshold bit 0 and the last bit sits in full-threshold bit 15.
- R7: Serial shifts leave the thresholds unchanged in parallel form. Parallel writes leave them unchanged in serial form.
- R8: Parallel readback works in serial form too.
- R9: The read and write byte pointers advance independently of each other.
- R10: `pgm_serial` is sampled only while `mrst`=1. Changing it afterwards does not change the programming form.
- R11: With `load_sel`=0, any pin pattern other than the three above is a no-op. With `load_sel`=1, no pattern alters the thresholds or `dout`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock: parallel writes, serial shifts |
| rclk | input | 1 | Read clock: parallel readback |
| mrst | input | 1 | Master reset, active high, synchronous |
| load_sel | input | 1 | 0 selects threshold access, 1 selects memory access; picks the defaults during reset |
| wr_n | input | 1 | Write enable, active low |
| rd_n | input | 1 | Read enable, active low |
| ser_n | input | 1 | Serial shift enable, active low |
| pgm_serial | input | 1 | 1 selects serial programming, sampled during reset |
| ser_din | input | 1 | Serial data bit |
| din | input | 9 | Parallel data in; bits 7:0 are used |
| dout | output | 9 | Readback byte in bits 7:0, bit 8 zero |
| mem_wr | output | 1 | Decoded memory write strobe |
| mem_rd | output | 1 | Decoded memory read strobe |
| empty_ofs | output | 16 | Almost-empty threshold |
| full_ofs | output | 16 | Almost-full threshold |

## Verification
Two functions can fall in the same write-clock cycle: master reset and a decoded threshold write. The bench provokes this by holding the parallel-write pattern, with a distinct data byte, throughout reset. It judges the result by two things: the thresholds must come out at the defaults, and the first write after reset must land in the empty low byte. The second collision is a pointer wrap on a write. It is judged by a fifth write that must overwrite the empty low byte, and by a readback whose pointer has moved by a different count from the write pointer.

// File: rtl/fifo_ofs_pkg.sv
package fifo_ofs_pkg;

  typedef enum logic [2:0] {
    OP_IDLE,
    OP_PWR,
    OP_PRD,
    OP_SHIFT,
    OP_MWR,
    OP_MRD
  } ofs_op_e;

  // Pin decode: memory side when load_sel is high, register side otherwise.
  function automatic ofs_op_e decode_op(input logic ld, input logic wen_n,
                                        input logic ren_n, input logic sen_n);
    ofs_op_e r;
    if (ld) begin
      if (!wen_n)      r = OP_MWR;
      else if (!ren_n) r = OP_MRD;
      else             r = OP_IDLE;
    end else begin
      case ({wen_n, ren_n, sen_n})
        3'b011:  r = OP_PWR;
        3'b101:  r = OP_PRD;
        3'b110:  r = OP_SHIFT;
        default: r = OP_IDLE;
      endcase
    end
    return r;
  endfunction

endpackage

// File: rtl/fol_decode.sv
module fol_decode
  import fifo_ofs_pkg::*;
(
  input  logic    load_sel,
  input  logic    wr_n,
  input  logic    rd_n,
  input  logic    ser_n,
  output ofs_op_e op,
  output logic    mem_wr,
  output logic    mem_rd
);

  always_comb begin
    op     = decode_op(load_sel, wr_n, rd_n, ser_n);
    mem_wr = (op == OP_MWR);
    mem_rd = (op == OP_MRD);
  end

endmodule

// File: rtl/fol_wr_bank.sv
module fol_wr_bank
  import fifo_ofs_pkg::*;
#(
  parameter int BYTE_W   = 8,
  parameter int OFS_W    = 16,
  parameter int NUM_OFS  = 2,
  parameter logic [OFS_W-1:0] DEF_LOW  = 16'h007F,
  parameter logic [OFS_W-1:0] DEF_HIGH = 16'h03FF,
  localparam int CHAIN_W  = OFS_W * NUM_OFS,
  localparam int NUM_REGS = CHAIN_W / BYTE_W,
  localparam int PTR_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic               clk,
  input  logic               mrst,
  input  logic               rst_ld,
  input  logic               mode_sel,
  input  ofs_op_e            op,
  input  logic [BYTE_W-1:0]  din_byte,
  input  logic               ser_din,
  output logic [CHAIN_W-1:0] chain,
  output logic               serial_mode
);

  localparam logic [PTR_W-1:0] LAST = PTR_W'(NUM_REGS - 1);

  logic [CHAIN_W-1:0] chain_q, chain_d, def_chain;
  logic [PTR_W-1:0]   wptr_q;
  logic               mode_q;
  logic               pwr_en, shift_en;

  assign pwr_en   = (op == OP_PWR)   && !mode_q;
  assign shift_en = (op == OP_SHIFT) &&  mode_q;

  assign def_chain = rst_ld ? {NUM_OFS{DEF_HIGH}} : {NUM_OFS{DEF_LOW}};

  always_comb begin
    chain_d = chain_q;
    if (shift_en) begin
      chain_d = {ser_din, chain_q[CHAIN_W-1:1]};
    end else if (pwr_en) begin
      for (int k = 0; k < NUM_REGS; k++) begin
        if (wptr_q == PTR_W'(k)) chain_d[k*BYTE_W +: BYTE_W] = din_byte;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (mrst) begin
      chain_q <= def_chain;
      wptr_q  <= '0;
      mode_q  <= mode_sel;
    end else begin
      chain_q <= chain_d;
      if (pwr_en) wptr_q <= (wptr_q == LAST) ? '0 : wptr_q + PTR_W'(1);
    end
  end

  assign chain       = chain_q;
  assign serial_mode = mode_q;

  p_wptr_wrap_r4: assert property (@(posedge clk) disable iff (mrst)
    (pwr_en && wptr_q == LAST) |=> (wptr_q == '0));

  p_shift_ignored_r7: assert property (@(posedge clk) disable iff (mrst)
    (!mode_q && op == OP_SHIFT) |=> $stable(chain_q));

  p_pwr_ignored_r7: assert property (@(posedge clk) disable iff (mrst)
    (mode_q && op == OP_PWR) |=> $stable(chain_q));

  p_mode_fixed_r10: assert property (@(posedge clk) disable iff (mrst)
    $stable(mode_q));

endmodule

// File: rtl/fol_rd_port.sv
module fol_rd_port
  import fifo_ofs_pkg::*;
#(
  parameter int BYTE_W  = 8,
  parameter int BUS_W   = 9,
  parameter int CHAIN_W = 32,
  localparam int NUM_REGS = CHAIN_W / BYTE_W,
  localparam int PTR_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic               clk,
  input  logic               mrst,
  input  ofs_op_e            op,
  input  logic [CHAIN_W-1:0] chain,
  output logic [BUS_W-1:0]   dout
);

  localparam logic [PTR_W-1:0] LAST = PTR_W'(NUM_REGS - 1);

  logic [PTR_W-1:0]  rptr_q;
  logic [BUS_W-1:0]  dout_q;
  logic [BYTE_W-1:0] sel_byte;
  logic              rd_en;

  assign rd_en = (op == OP_PRD);

  always_comb begin
    sel_byte = '0;
    for (int k = 0; k < NUM_REGS; k++) begin
      if (rptr_q == PTR_W'(k)) sel_byte = chain[k*BYTE_W +: BYTE_W];
    end
  end

  always_ff @(posedge clk) begin
    if (mrst) begin
      rptr_q <= '0;
      dout_q <= '0;
    end else if (rd_en) begin
      dout_q <= {{(BUS_W-BYTE_W){1'b0}}, sel_byte};
      rptr_q <= (rptr_q == LAST) ? '0 : rptr_q + PTR_W'(1);
    end
  end

  assign dout = dout_q;

  p_rptr_step_r5: assert property (@(posedge clk) disable iff (mrst)
    rd_en |=> (rptr_q == (($past(rptr_q) == LAST) ? '0 : $past(rptr_q) + PTR_W'(1))));

  p_dout_hold_r5: assert property (@(posedge clk) disable iff (mrst)
    !rd_en |=> $stable(dout_q));

endmodule

// File: rtl/fifo_offset_loader.sv
module fifo_offset_loader
  import fifo_ofs_pkg::*;
#(
  parameter int BYTE_W  = 8,
  parameter int BUS_W   = 9,
  parameter int OFS_W   = 16,
  parameter logic [OFS_W-1:0] DEF_LOW  = 16'h007F,
  parameter logic [OFS_W-1:0] DEF_HIGH = 16'h03FF
) (
  input  logic             wclk,
  input  logic             rclk,
  input  logic             mrst,
  input  logic             load_sel,
  input  logic             wr_n,
  input  logic             rd_n,
  input  logic             ser_n,
  input  logic             pgm_serial,
  input  logic             ser_din,
  input  logic [BUS_W-1:0] din,
  output logic [BUS_W-1:0] dout,
  output logic             mem_wr,
  output logic             mem_rd,
  output logic [OFS_W-1:0] empty_ofs,
  output logic [OFS_W-1:0] full_ofs
);

  localparam int NUM_OFS = 2;
  localparam int CHAIN_W = OFS_W * NUM_OFS;

  ofs_op_e            op;
  logic [CHAIN_W-1:0] chain;
  logic               serial_mode;

  fol_decode u_dec (
    .load_sel (load_sel),
    .wr_n     (wr_n),
    .rd_n     (rd_n),
    .ser_n    (ser_n),
    .op       (op),
    .mem_wr   (mem_wr),
    .mem_rd   (mem_rd)
  );

  fol_wr_bank #(
    .BYTE_W   (BYTE_W),
    .OFS_W    (OFS_W),
    .NUM_OFS  (NUM_OFS),
    .DEF_LOW  (DEF_LOW),
    .DEF_HIGH (DEF_HIGH)
  ) u_wr (
    .clk         (wclk),
    .mrst        (mrst),
    .rst_ld      (load_sel),
    .mode_sel    (pgm_serial),
    .op          (op),
    .din_byte    (din[BYTE_W-1:0]),
    .ser_din     (ser_din),
    .chain       (chain),
    .serial_mode (serial_mode)
  );

  fol_rd_port #(
    .BYTE_W  (BYTE_W),
    .BUS_W   (BUS_W),
    .CHAIN_W (CHAIN_W)
  ) u_rd (
    .clk   (rclk),
    .mrst  (mrst),
    .op    (op),
    .chain (chain),
    .dout  (dout)
  );

  assign empty_ofs = chain[OFS_W-1:0];
  assign full_ofs  = chain[CHAIN_W-1:OFS_W];

  p_strobe_excl_r1: assert property (@(posedge wclk) disable iff (mrst)
    !(mem_wr && mem_rd));

  p_strobe_regside_r1: assert property (@(posedge wclk) disable iff (mrst)
    !load_sel |-> !(mem_wr || mem_rd));

  p_reset_default_r2: assert property (@(posedge wclk) disable iff (mrst)
    ($past(mrst) && !$past(load_sel)) |-> (empty_ofs == DEF_LOW && full_ofs == DEF_LOW));

  p_reset_default_r3: assert property (@(posedge wclk) disable iff (mrst)
    ($past(mrst) && $past(load_sel)) |-> (empty_ofs == DEF_HIGH && full_ofs == DEF_HIGH));

  p_mode_used_r6: assert property (@(posedge wclk) disable iff (mrst)
    (serial_mode && op == OP_SHIFT) |=> (full_ofs[OFS_W-1] == $past(ser_din)));

endmodule

// File: tb/fifo_offset_loader_tb_top.sv
module fifo_offset_loader_tb_top;

  logic       wclk = 1'b0, rclk = 1'b0;
  logic       mrst = 1'b1, load_sel = 1'b0, wr_n = 1'b1, rd_n = 1'b1, ser_n = 1'b1;
  logic       pgm_serial = 1'b0, ser_din = 1'b0;
  logic [8:0] din = '0;
  logic [8:0] dout;
  logic       mem_wr, mem_rd;
  logic [15:0] empty_ofs, full_ofs;

  int n_checks = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 wclk = ~wclk;
  initial begin #2; forever #5 rclk = ~rclk; end

  fifo_offset_loader dut_i (
    .wclk(wclk), .rclk(rclk), .mrst(mrst), .load_sel(load_sel), .wr_n(wr_n),
    .rd_n(rd_n), .ser_n(ser_n), .pgm_serial(pgm_serial), .ser_din(ser_din),
    .din(din), .dout(dout), .mem_wr(mem_wr), .mem_rd(mem_rd),
    .empty_ofs(empty_ofs), .full_ofs(full_ofs)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_idle();
    load_sel = 1'b0; wr_n = 1'b1; rd_n = 1'b1; ser_n = 1'b1;
  endtask

  task automatic do_reset(input logic ld, input logic ser, input logic wr_during);
    @(negedge wclk);
    mrst = 1'b1; load_sel = ld; pgm_serial = ser;
    wr_n = wr_during ? 1'b0 : 1'b1; rd_n = 1'b1; ser_n = 1'b1; din = 9'h099;
    repeat (3) @(negedge wclk);
    mrst = 1'b0; set_idle();
  endtask

  task automatic pins_cycle(input logic ld, input logic w, input logic r, input logic s,
                            input logic [8:0] d, input logic sd);
    @(negedge wclk);
    load_sel = ld; wr_n = w; rd_n = r; ser_n = s; din = d; ser_din = sd;
    @(negedge wclk);
    set_idle();
  endtask

  task automatic pwrite(input logic [7:0] b);  pins_cycle(0, 0, 1, 1, {1'b0, b}, 0); endtask
  task automatic pread();                      pins_cycle(0, 1, 0, 1, 9'h0, 0);       endtask
  task automatic shift1(input logic b);        pins_cycle(0, 1, 1, 0, 9'h0, b);       endtask

  task automatic t_reset_low();
    do_reset(0, 0, 0);
    check("R2 empty default", 32'(empty_ofs), 32'h007F);
    check("R2 full default", 32'(full_ofs), 32'h007F);
    check("R5 dout reset", 32'(dout), 32'h0);
  endtask

  task automatic t_strobes();
    for (int v = 0; v < 16; v++) begin
      logic ld, w, r, s, ew, er;
      ld = v[3]; w = v[2]; r = v[1]; s = v[0];
      ew = ld && !w;
      er = ld && w && !r;
      @(negedge wclk);
      mrst = 1'b1;
      load_sel = ld; wr_n = w; rd_n = r; ser_n = s;
      #1;
      check("R1 mem_wr", 32'(mem_wr), 32'(ew));
      check("R1 mem_rd", 32'(mem_rd), 32'(er));
    end
    set_idle();
    mrst = 1'b0;
  endtask

  task automatic t_par_write();
    do_reset(0, 0, 0);
    pwrite(8'h11); pwrite(8'h22); pwrite(8'h33); pwrite(8'h44);
    check("R4 empty after 4 writes", 32'(empty_ofs), 32'h2211);
    check("R4 full after 4 writes", 32'(full_ofs), 32'h4433);
    pwrite(8'h55);
    check("R4 wrap to empty LSB", 32'(empty_ofs), 32'h2255);
    check("R4 full untouched by wrap", 32'(full_ofs), 32'h4433);
  endtask

  task automatic t_par_read();
    pread(); check("R5 read byte0", 32'(dout), 32'h055);
    pread(); check("R5 read byte1", 32'(dout), 32'h022);
    repeat (3) @(negedge wclk);
    check("R5 dout holds", 32'(dout), 32'h022);
    pread(); check("R5 read byte2", 32'(dout), 32'h033);
    pread(); check("R5 read byte3", 32'(dout), 32'h044);
    pread(); check("R5 read wrap", 32'(dout), 32'h055);
    pwrite(8'h66);
    check("R9 write ptr independent of reads", 32'(empty_ofs), 32'h6655);
  endtask

  task automatic t_noop();
    pins_cycle(0, 0, 0, 1, 9'h0AA, 0);
    pins_cycle(0, 1, 1, 1, 9'h0AA, 0);
    pins_cycle(0, 0, 1, 0, 9'h0AA, 0);
    pins_cycle(1, 0, 1, 1, 9'h0AA, 0);
    pins_cycle(1, 1, 0, 0, 9'h0AA, 0);
    check("R11 empty after no-ops", 32'(empty_ofs), 32'h6655);
    check("R11 full after no-ops", 32'(full_ofs), 32'h4433);
    check("R11 dout after no-ops", 32'(dout), 32'h055);
  endtask

  task automatic t_reset_high();
    do_reset(1, 0, 0);
    check("R3 empty default", 32'(empty_ofs), 32'h03FF);
    check("R3 full default", 32'(full_ofs), 32'h03FF);
    pread(); check("R3 read byte0", 32'(dout), 32'h0FF);
    pread(); check("R3 read byte1", 32'(dout), 32'h003);
  endtask

  task automatic t_shift_ignored();
    do_reset(0, 0, 0);
    for (int i = 0; i < 5; i++) shift1(1'b1);
    check("R7 shift ignored (empty)", 32'(empty_ofs), 32'h007F);
    check("R7 shift ignored (full)", 32'(full_ofs), 32'h007F);
  endtask

  task automatic t_serial();
    logic [31:0] pat;
    pat = {16'h1E69, 16'hA5C3};
    do_reset(0, 1, 0);
    pgm_serial = 1'b0;
    for (int i = 0; i < 32; i++) shift1(pat[i]);
    check("R6 empty after 32 shifts", 32'(empty_ofs), 32'hA5C3);
    check("R6 full after 32 shifts", 32'(full_ofs), 32'h1E69);
    check("R10 serial form kept", 32'({full_ofs, empty_ofs}), pat);
    pwrite(8'hEE);
    check("R7 write ignored in serial", 32'({full_ofs, empty_ofs}), pat);
    pread(); check("R8 serial readback 0", 32'(dout), 32'h0C3);
    pread(); check("R8 serial readback 1", 32'(dout), 32'h0A5);
    pread(); check("R8 serial readback 2", 32'(dout), 32'h069);
    pread(); check("R8 serial readback 3", 32'(dout), 32'h01E);
    shift1(1'b1);
    pat = {1'b1, pat[31:1]};
    check("R6 one more shift", 32'({full_ofs, empty_ofs}), pat);
  endtask

  task automatic t_reset_collision();
    do_reset(0, 0, 1);
    check("R2 reset beats write (empty)", 32'(empty_ofs), 32'h007F);
    check("R2 reset beats write (full)", 32'(full_ofs), 32'h007F);
    pwrite(8'h01);
    check("R4 first write after reset", 32'(empty_ofs), 32'h0001);
  endtask

  initial begin
    #100_000;
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset_low();
    t_strobes();
    t_par_write();
    t_par_read();
    t_noop();
    t_reset_high();
    t_shift_ignored();
    t_serial();
    t_reset_collision();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule